// File: doc/BRIEF.md
# Dual-Clock Gray-Pointer FIFO

This block is a first-in first-out queue that carries data words from one clock domain to another whose clock has no fixed relation to the first. A producer writes on the write clock. A consumer reads on the read clock. Storage is a small register array. Each side owns a binary pointer that is one bit wider than the array address. The extra top bit marks how many times the pointer has wrapped. Each pointer is held as a registered Gray value, and that value alone crosses into the other domain through a flip-flop chain whose length is set by a parameter.

The write side raises `wr_full` and the read side raises `rd_empty`. Each flag comes from a direct comparison of Gray values, and no Gray value is converted back to binary. Because each flag looks at a delayed copy of the far pointer, it can stay set a few cycles longer than the true fill level requires. It never clears too early. Read data is shown ahead: while `rd_empty` is low, `rd_data` already holds the oldest stored word, and a read strobe moves on to the next one.

Top module: `dcfifo_gray`

## Requirements
- R1: While `wr_rst` and `rd_rst` are held high for at least one edge of their own clocks, the block comes out with `rd_empty` = 1 and `wr_full` = 0.
- R2: A write clock edge stores `wr_data` and advances the write pointer only when `wr_en` = 1 and `wr_full` = 0. A write presented while `wr_full` = 1 is discarded and changes no stored word.
- R3: A read clock edge advances the read pointer only when `rd_en` = 1 and `rd_empty` = 0. A read strobe while `rd_empty` = 1 has no effect.
- R4: Words leave in the order they were accepted. Whenever `rd_empty` = 0, `rd_data` presents the oldest unread word without waiting for a read strobe.
- R5: With no reads, `wr_full` rises on the write edge that accepts the DEPTH-th word, and stays 0 before that edge.
- R6: After a write into an empty queue, `rd_empty` stays high until exactly SYNC_STAGES rising read-clock edges have followed the write edge. It falls after the last of those edges.
- R7: After a read from a full queue, `wr_full` stays high until exactly SYNC_STAGES rising write-clock edges have followed the read edge. It falls after the last of those edges.
- R8: Each Gray pointer changes in at most one bit from one clock edge to the next. Order and flags stay correct across many pointer wraps (more than 2*DEPTH transfers).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst | input | 1 | Write-domain synchronous reset, active high |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| wr_full | output | 1 | Queue has no free entry (write domain) |
| rd_clk | input | 1 | Read-domain clock |
| rd_rst | input | 1 | Read-domain synchronous reset, active high |
| rd_en | input | 1 | Read request; consumes the presented word |
| rd_data | output | DATA_W | Oldest unread word, valid while `rd_empty` is low |
| rd_empty | output | 1 | Queue holds no unread word (read domain) |

## Verification
The properties assume that each reset is applied from time zero until its own clock has ticked at least once. They also assume that the two clocks never place a rising edge at the same instant, so that every Gray sample is cleanly one step old or new. The bench meets both assumptions. It starts with both resets high. Its write clock runs at 20 ns and its read clock at 35 ns with a half-nanosecond phase offset, so the edges of the two clocks never meet. The bench deliberately drives strobes against a full or an empty queue, because those are the cases in which the hold properties have to stop a pointer from moving.

// File: rtl/cdcq_pkg.sv
`timescale 1ns/1ps
package cdcq_pkg;

    // Which flag a pointer block derives from its own and the far pointer.
    typedef enum logic {
        SIDE_WRITE = 1'b0,
        SIDE_READ  = 1'b1
    } side_e;

    // Pointer width for a power-of-two depth: address bits plus a wrap bit.
    function automatic int ptr_width(input int depth);
        return $clog2(depth) + 1;
    endfunction

    // Smallest legal synchronizer length.
    localparam int MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/cdcq_sync.sv
`timescale 1ns/1ps
module cdcq_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Flip-flop chain in the receiving domain; stage 0 may resolve slowly.
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/cdcq_ptr.sv
`timescale 1ns/1ps
module cdcq_ptr
    import cdcq_pkg::*;
#(
    parameter int    ADDR_W = 4,
    parameter side_e SIDE   = SIDE_WRITE,
    localparam int   PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step_req,
    input  logic [PTR_W-1:0]  far_gray,
    output logic [ADDR_W-1:0] addr,
    output logic [PTR_W-1:0]  gray,
    output logic              flag,
    output logic              step
);
    // Mask that flips the two top bits of a Gray pointer.
    localparam logic [PTR_W-1:0] TOP2_MASK = ~({PTR_W{1'b1}} >> 2);

    logic [PTR_W-1:0] bin_q;
    logic [PTR_W-1:0] gray_q;
    logic [PTR_W-1:0] bin_nx;
    logic [PTR_W-1:0] gray_nx;

    generate
        if (SIDE == SIDE_WRITE) begin : g_full
            // One full lap ahead: top two Gray bits differ, the rest match.
            assign flag = (gray_q == (far_gray ^ TOP2_MASK));
        end else begin : g_empty
            assign flag = (gray_q == far_gray);
        end
    endgenerate

    assign step    = step_req && !flag;
    assign bin_nx  = bin_q + PTR_W'(1);
    assign gray_nx = bin_nx ^ (bin_nx >> 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else if (step) begin
            bin_q  <= bin_nx;
            gray_q <= gray_nx;
        end
    end

    assign addr = bin_q[ADDR_W-1:0];
    assign gray = gray_q;
endmodule

// File: rtl/cdcq_store.sv
`timescale 1ns/1ps
module cdcq_store #(
    parameter int  DATA_W = 8,
    parameter int  ADDR_W = 4,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cell_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cell_q[waddr] <= wdata;
    end

    // Show-ahead read: the addressed entry is always on the output.
    assign rdata = cell_q[raddr];
endmodule

// File: rtl/dcfifo_gray.sv
`timescale 1ns/1ps
module dcfifo_gray
    import cdcq_pkg::*;
#(
    parameter int  DATA_W      = 8,
    parameter int  DEPTH       = 16,
    parameter int  SYNC_STAGES = 2,
    localparam int ADDR_W      = $clog2(DEPTH),
    localparam int PTR_W       = ptr_width(DEPTH)
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int SYNC_N = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

    logic [PTR_W-1:0]  wr_gray;
    logic [PTR_W-1:0]  rd_gray;
    logic [PTR_W-1:0]  rd_gray_at_wr;
    logic [PTR_W-1:0]  wr_gray_at_rd;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_step;
    logic              rd_step;

    cdcq_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_WRITE)) u_wptr (
        .clk      (wr_clk),
        .rst      (wr_rst),
        .step_req (wr_en),
        .far_gray (rd_gray_at_wr),
        .addr     (wr_addr),
        .gray     (wr_gray),
        .flag     (wr_full),
        .step     (wr_step)
    );

    cdcq_ptr #(.ADDR_W(ADDR_W), .SIDE(SIDE_READ)) u_rptr (
        .clk      (rd_clk),
        .rst      (rd_rst),
        .step_req (rd_en),
        .far_gray (wr_gray_at_rd),
        .addr     (rd_addr),
        .gray     (rd_gray),
        .flag     (rd_empty),
        .step     (rd_step)
    );

    cdcq_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_w2r (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (wr_gray),
        .q   (wr_gray_at_rd)
    );

    cdcq_sync #(.W(PTR_W), .STAGES(SYNC_N)) u_r2w (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (rd_gray),
        .q   (rd_gray_at_wr)
    );

    cdcq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .wclk  (wr_clk),
        .we    (wr_step),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    // The read step is consumed only by the pointer register.
    logic unused_rd_step;
    assign unused_rd_step = rd_step;
endmodule

// File: rtl/dcfifo_gray_chk.sv
`timescale 1ns/1ps
module dcfifo_gray_chk #(
    parameter int PTR_W = 5
) (
    input logic             wr_clk,
    input logic             wr_rst,
    input logic             wr_en,
    input logic             wr_full,
    input logic [PTR_W-1:0] wr_gray,
    input logic             rd_clk,
    input logic             rd_rst,
    input logic             rd_en,
    input logic             rd_empty,
    input logic [PTR_W-1:0] rd_gray
);
    // R8: write-side Gray pointer moves by at most one bit per edge
    p_gray_step_w_r8: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);

    // R8: read-side Gray pointer moves by at most one bit per edge
    p_gray_step_r_r8: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $countones(rd_gray ^ $past(rd_gray)) <= 1);

    // R2: a write against a full queue leaves the pointer where it was
    p_no_overflow_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && wr_full) |=> $stable(wr_gray));

    // R2: an accepted write moves the pointer
    p_write_moves_r2: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && !wr_full) |=> (wr_gray != $past(wr_gray)));

    // R3: a read against an empty queue leaves the pointer where it was
    p_no_underflow_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && rd_empty) |=> $stable(rd_gray));

    // R3: an accepted read moves the pointer
    p_read_moves_r3: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && !rd_empty) |=> (rd_gray != $past(rd_gray)));
endmodule

bind dcfifo_gray dcfifo_gray_chk #(.PTR_W(PTR_W)) u_chk (
    .wr_clk   (wr_clk),
    .wr_rst   (wr_rst),
    .wr_en    (wr_en),
    .wr_full  (wr_full),
    .wr_gray  (wr_gray),
    .rd_clk   (rd_clk),
    .rd_rst   (rd_rst),
    .rd_en    (rd_en),
    .rd_empty (rd_empty),
    .rd_gray  (rd_gray)
);

// File: tb/test_dcfifo_gray.sv
`timescale 1ns/1ps
module test_dcfifo_gray;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int SYNC   = 2;
    localparam int STREAM = 200;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst = 1'b1;
    logic              rd_rst = 1'b1;
    logic              wr_en  = 1'b0;
    logic              rd_en  = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              wr_full;
    logic              rd_empty;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // 50 MHz write clock; unrelated 35 ns read clock, offset so edges never meet.
    always #10 wr_clk = ~wr_clk;
    initial begin
        #3;
        forever #17.5 rd_clk = ~rd_clk;
    end

    dcfifo_gray #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SYNC_STAGES(SYNC)) i_dcfifo_gray (
        .wr_clk   (wr_clk),
        .wr_rst   (wr_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .wr_full  (wr_full),
        .rd_clk   (rd_clk),
        .rd_rst   (rd_rst),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .rd_empty (rd_empty)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (6) @(negedge wr_clk);
    endtask

    task automatic push(input logic [DATA_W-1:0] v);
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = v;
        @(negedge wr_clk);
        wr_en   = 1'b0;
    endtask

    task automatic pop_check(input logic [DATA_W-1:0] exp, input string req);
        @(negedge rd_clk);
        check(rd_empty == 1'b0, req, int'(rd_empty), 0);
        check(rd_data == exp, req, int'(rd_data), int'(exp));
        rd_en = 1'b1;
        @(negedge rd_clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge rd_clk);
        wr_rst = 1'b0;
        rd_rst = 1'b0;
        @(negedge wr_clk);
        @(negedge rd_clk);
        check(rd_empty == 1'b1, "R1 empty after reset", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R1 full after reset", int'(wr_full), 0);
    endtask

    task automatic t_empty_latency();
        int n = 0;
        @(negedge wr_clk);
        wr_en   = 1'b1;
        wr_data = 8'hA5;
        @(posedge wr_clk);
        #0.25 wr_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge rd_clk);
            #0.25;
            n++;
            if (!rd_empty) break;
        end
        check(n == SYNC, "R6 empty release edges", n, SYNC);
        pop_check(8'hA5, "R4 single word");
        check(rd_empty == 1'b1, "R3 empty after last read", int'(rd_empty), 1);
    endtask

    task automatic t_underflow();
        @(negedge rd_clk);
        rd_en = 1'b1;
        repeat (5) @(negedge rd_clk);
        rd_en = 1'b0;
        check(rd_empty == 1'b1, "R3 empty held under reads", int'(rd_empty), 1);
        push(8'h3C);
        settle();
        pop_check(8'h3C, "R3 read while empty ignored");
        @(negedge rd_clk);
        check(rd_empty == 1'b1, "R3 empty after one pop", int'(rd_empty), 1);
    endtask

    task automatic t_fill_and_release();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge wr_clk);
            if (i == DEPTH - 1)
                check(wr_full == 1'b0, "R5 not full one short", int'(wr_full), 0);
            wr_en   = 1'b1;
            wr_data = DATA_W'(8'h10 + i);
        end
        @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_full == 1'b1, "R5 full after DEPTH writes", int'(wr_full), 1);
        // Writes against a full queue must be dropped.
        wr_en   = 1'b1;
        wr_data = 8'hEE;
        repeat (4) @(negedge wr_clk);
        wr_en = 1'b0;
        check(wr_full == 1'b1, "R2 full held under writes", int'(wr_full), 1);
        settle();
        // One read, then count write edges until full drops.
        @(negedge rd_clk);
        check(rd_data == 8'h10, "R4 head of full queue", int'(rd_data), 16);
        rd_en = 1'b1;
        @(posedge rd_clk);
        #0.25 rd_en = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(posedge wr_clk);
            #0.25;
            n++;
            if (!wr_full) break;
        end
        check(n == SYNC, "R7 full release edges", n, SYNC);
        for (int i = 1; i < DEPTH; i++)
            pop_check(DATA_W'(8'h10 + i), "R2 R4 drain after overflow");
        @(negedge rd_clk);
        check(rd_empty == 1'b1, "R2 no dropped word stored", int'(rd_empty), 1);
    endtask

    task automatic t_stream(input int wgap, input int rgap);
        logic [DATA_W-1:0] model[$];
        int bad = 0;
        fork
            begin
                int sent = 0;
                while (sent < STREAM) begin
                    @(negedge wr_clk);
                    if (!wr_full && (($urandom % (wgap + 1)) == 0)) begin
                        wr_en   = 1'b1;
                        wr_data = DATA_W'($urandom);
                        model.push_back(wr_data);
                        sent++;
                    end else begin
                        wr_en = 1'b0;
                    end
                end
                @(negedge wr_clk);
                wr_en = 1'b0;
            end
            begin
                int got = 0;
                while (got < STREAM) begin
                    @(negedge rd_clk);
                    if (!rd_empty && (($urandom % (rgap + 1)) == 0)) begin
                        if (model.size() == 0 || rd_data != model[0]) bad++;
                        if (model.size() != 0) void'(model.pop_front());
                        rd_en = 1'b1;
                        got++;
                    end else begin
                        rd_en = 1'b0;
                    end
                end
                @(negedge rd_clk);
                rd_en = 1'b0;
            end
        join
        check(bad == 0, "R4 R8 stream order across wraps", bad, 0);
        settle();
        check(rd_empty == 1'b1, "R8 empty after stream", int'(rd_empty), 1);
        check(wr_full == 1'b0, "R8 not full after stream", int'(wr_full), 0);
    endtask

    initial begin
        t_reset();
        t_empty_latency();
        t_underflow();
        t_fill_and_release();
        t_stream(0, 3);
        t_stream(3, 0);
        t_stream(1, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule